// File: doc/BRIEF.md
# Graft-and-Shortcut Connected Components Engine

This block labels the connected components of an undirected graph held in on-chip storage. Software first fills an edge store in which every undirected edge takes two directed slots, one for each direction. It then gives a vertex count and a slot count and pulses a start input. The engine writes every vertex's label as its own index. It then runs rounds until the graph stops changing. Each round has a hook pass over all directed slots, which attaches one tree root below a smaller label. It then has a flatten pass, which points every vertex straight at its root by repeated pointer jumping.

The label store has one read port with one cycle of latency. For this reason each hook check is a short sequence: fetch the slot, read the label of each endpoint, read the label of the second endpoint's label, then decide and write. The engine keeps a single "something hooked" flag per round and stops after a round that leaves the flag clear. Every tree is a star after each flatten pass, so no separate star test is needed. When the engine finishes, the label read port returns, for any vertex, the smallest vertex index in its component.

Top module: `cc_engine`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: While `busy` is low, a cycle with `load_we` high stores the pair (`load_u`, `load_v`) in edge slot `load_idx`. While `busy` is high, `load_we` has no effect on any slot.
- R3: A `start` pulse while `busy` is low captures `cfg_nv` as the vertex count n and `cfg_ne` as the number of directed slots to scan. `busy` is high and `done` is low from the next cycle.
- R4: A run first sets the label of every vertex i below n to i.
- R5: In the hook pass, a directed slot (u,v) changes the labels only when label(u) < label(v) and label(label(v)) equals label(v). The change sets label(label(v)) to label(u) and marks the round as having hooked.
- R6: In the flatten pass, each vertex i is rewritten to label(label(i)) repeatedly until label(label(i)) equals label(i). Labels never increase after the initial write.
- R7: A run ends after the first round whose hook pass changes nothing. `done` then goes high and `busy` goes low, and both keep these values until the next accepted `start`.
- R8: After a run, two vertices have equal labels exactly when they are connected through the loaded slots. That label is the smallest vertex index in their component, and a vertex with no edges keeps its own index.
- R9: While `busy` is low, `rd_label` gives the label of the vertex on `rd_addr` one cycle after that address is presented.
- R10: A run with `cfg_ne` equal to 0 leaves every vertex i below n labelled i.
- R11: A `start` pulse while `busy` is high is ignored. The run in progress continues with its captured counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we | input | 1 | Edge slot write strobe |
| load_idx | input | EAW | Edge slot index to write |
| load_u | input | VW | Source endpoint of the directed slot |
| load_v | input | VW | Target endpoint of the directed slot |
| cfg_nv | input | VW+1 | Vertex count n, from 0 to 2**VW |
| cfg_ne | input | EAW+1 | Number of directed slots to scan, from 0 to EDEPTH |
| start | input | 1 | Begin a labelling run |
| rd_addr | input | VW | Vertex whose label is read |
| rd_label | output | VW | Label of the vertex addressed in the previous cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished and labels are final |

## Verification
The embedded properties take for granted that every loaded endpoint is below the vertex count of the run that scans it, that the slot count never exceeds the edge store depth, and that each undirected edge is present in both directions. Under those conditions labels only move downwards and every written label stays below n. The stimulus builds every graph through a helper that always writes both directions together and draws endpoints only below the chosen vertex count. A deliberate write and a second start during a run are issued only to check that they are rejected at the edge of the block.

// File: rtl/cc_pkg.sv
package cc_pkg;

   // Controller phases of one labelling run
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_INIT,
      ST_ROUND,
      ST_G_FETCH,
      ST_G_RU,
      ST_G_RV,
      ST_G_RP,
      ST_G_DEC,
      ST_S_RI,
      ST_S_RP,
      ST_S_CHK,
      ST_DONE
   } cc_state_e;

endpackage

// File: rtl/cc_edge_mem.sv
module cc_edge_mem #(
   parameter int VW     = 5,
   parameter int EDEPTH = 64,
   localparam int EAW   = $clog2(EDEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [EAW-1:0] waddr,
   input  logic [VW-1:0]  wu,
   input  logic [VW-1:0]  wv,
   input  logic [EAW-1:0] raddr,
   output logic [VW-1:0]  ru,
   output logic [VW-1:0]  rv
);

   logic [VW-1:0] src_mem [EDEPTH];
   logic [VW-1:0] dst_mem [EDEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         src_mem[waddr] <= wu;
         dst_mem[waddr] <= wv;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ru <= '0;
         rv <= '0;
      end else begin
         ru <= src_mem[raddr];
         rv <= dst_mem[raddr];
      end
   end

endmodule

// File: rtl/cc_label_mem.sv
module cc_label_mem #(
   parameter int VW    = 5,
   localparam int NMAX = 1 << VW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_init,
   input  logic [VW-1:0] wr_addr,
   input  logic [VW-1:0] wr_data,
   input  logic [VW-1:0] rd_addr,
   output logic [VW-1:0] rd_data
);

   logic [VW-1:0] lbl [NMAX];

   always_ff @(posedge clk) begin
      if (wr_en) lbl[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= lbl[rd_addr];
   end

   // After the initial write, every change moves a label strictly downwards
   assert_label_decrease_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_init) |-> (wr_data < lbl[wr_addr]));

   // The initial write gives each vertex its own index
   assert_init_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_init) |=> (lbl[$past(wr_addr)] == $past(wr_addr)));

endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
   import cc_pkg::*;
#(
   parameter int VW     = 5,
   parameter int EDEPTH = 64,
   localparam int EAW   = $clog2(EDEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [VW:0]    cfg_nv,
   input  logic [EAW:0]   cfg_ne,
   output logic [EAW-1:0] edge_raddr,
   input  logic [VW-1:0]  edge_u,
   input  logic [VW-1:0]  edge_v,
   output logic [VW-1:0]  lbl_raddr,
   input  logic [VW-1:0]  lbl_rdata,
   output logic           lbl_we,
   output logic           lbl_init,
   output logic [VW-1:0]  lbl_waddr,
   output logic [VW-1:0]  lbl_wdata,
   output logic           busy,
   output logic           done
);

   localparam logic [VW:0]  V_ONE = 1;
   localparam logic [EAW:0] E_ONE = 1;

   cc_state_e      st, st_d;
   logic [VW:0]    n_q, n_d;
   logic [EAW:0]   ne_q, ne_d;
   logic [VW:0]    vi, vi_d;
   logic [EAW:0]   e_idx, e_d;
   logic           hooked, hooked_d;
   logic [VW-1:0]  v_q, v_d;
   logic [VW-1:0]  du_q, du_d;
   logic [VW-1:0]  dv_q, dv_d;
   logic [VW-1:0]  cur, cur_d;

   assign busy       = (st != ST_IDLE) && (st != ST_DONE);
   assign done       = (st == ST_DONE);
   assign edge_raddr = e_idx[EAW-1:0];

   always_comb begin
      st_d      = st;
      n_d       = n_q;
      ne_d      = ne_q;
      vi_d      = vi;
      e_d       = e_idx;
      hooked_d  = hooked;
      v_d       = v_q;
      du_d      = du_q;
      dv_d      = dv_q;
      cur_d     = cur;
      lbl_raddr = '0;
      lbl_we    = 1'b0;
      lbl_init  = 1'b0;
      lbl_waddr = '0;
      lbl_wdata = '0;
      case (st)
         ST_IDLE, ST_DONE: begin
            if (start) begin
               st_d = ST_INIT;
               n_d  = cfg_nv;
               ne_d = cfg_ne;
               vi_d = '0;
            end
         end
         ST_INIT: begin
            if (vi == n_q) begin
               st_d = ST_ROUND;
            end else begin
               lbl_we    = 1'b1;
               lbl_init  = 1'b1;
               lbl_waddr = vi[VW-1:0];
               lbl_wdata = vi[VW-1:0];
               vi_d      = vi + V_ONE;
            end
         end
         ST_ROUND: begin
            hooked_d = 1'b0;
            e_d      = '0;
            vi_d     = '0;
            st_d     = (ne_q == '0) ? ST_S_RI : ST_G_FETCH;
         end
         ST_G_FETCH: begin
            st_d = ST_G_RU;
         end
         ST_G_RU: begin
            v_d       = edge_v;
            lbl_raddr = edge_u;
            st_d      = ST_G_RV;
         end
         ST_G_RV: begin
            du_d      = lbl_rdata;
            lbl_raddr = v_q;
            st_d      = ST_G_RP;
         end
         ST_G_RP: begin
            dv_d      = lbl_rdata;
            lbl_raddr = lbl_rdata;
            st_d      = ST_G_DEC;
         end
         ST_G_DEC: begin
            if ((du_q < dv_q) && (lbl_rdata == dv_q)) begin
               lbl_we    = 1'b1;
               lbl_waddr = dv_q;
               lbl_wdata = du_q;
               hooked_d  = 1'b1;
            end
            e_d  = e_idx + E_ONE;
            st_d = ((e_idx + E_ONE) == ne_q) ? ST_S_RI : ST_G_FETCH;
         end
         ST_S_RI: begin
            if (vi == n_q) begin
               st_d = hooked ? ST_ROUND : ST_DONE;
            end else begin
               lbl_raddr = vi[VW-1:0];
               st_d      = ST_S_RP;
            end
         end
         ST_S_RP: begin
            cur_d     = lbl_rdata;
            lbl_raddr = lbl_rdata;
            st_d      = ST_S_CHK;
         end
         ST_S_CHK: begin
            if (lbl_rdata == cur) begin
               vi_d = vi + V_ONE;
               st_d = ST_S_RI;
            end else begin
               lbl_we    = 1'b1;
               lbl_waddr = vi[VW-1:0];
               lbl_wdata = lbl_rdata;
               cur_d     = lbl_rdata;
               lbl_raddr = lbl_rdata;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         n_q    <= '0;
         ne_q   <= '0;
         vi     <= '0;
         e_idx  <= '0;
         hooked <= 1'b0;
         v_q    <= '0;
         du_q   <= '0;
         dv_q   <= '0;
         cur    <= '0;
      end else begin
         st     <= st_d;
         n_q    <= n_d;
         ne_q   <= ne_d;
         vi     <= vi_d;
         e_idx  <= e_d;
         hooked <= hooked_d;
         v_q    <= v_d;
         du_q   <= du_d;
         dv_q   <= dv_d;
         cur    <= cur_d;
      end
   end

   // The hook pass never addresses a slot beyond the captured count
   assert_slot_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st inside {ST_G_FETCH, ST_G_RU, ST_G_RV, ST_G_RP, ST_G_DEC}) |-> (e_idx < ne_q));

   // Every label written stays inside the vertex range of the run
   assert_label_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lbl_we |-> ({1'b0, lbl_wdata} < n_q));

   // A second start during a run leaves the captured counts alone
   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ((n_q == $past(n_q)) && (ne_q == $past(ne_q))));

   // The flatten pass only follows pointers once the hook pass is over
   assert_flatten_no_hook_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_S_CHK) |-> $stable(hooked));

endmodule

// File: rtl/cc_engine.sv
module cc_engine #(
   parameter int VW     = 5,
   parameter int EDEPTH = 64,
   localparam int EAW   = $clog2(EDEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_we,
   input  logic [EAW-1:0] load_idx,
   input  logic [VW-1:0]  load_u,
   input  logic [VW-1:0]  load_v,
   input  logic [VW:0]    cfg_nv,
   input  logic [EAW:0]   cfg_ne,
   input  logic           start,
   input  logic [VW-1:0]  rd_addr,
   output logic [VW-1:0]  rd_label,
   output logic           busy,
   output logic           done
);

   initial begin
      assert (VW >= 1 && VW <= 12) else $error("cc_engine: VW out of range");
      assert (EDEPTH >= 2 && (1 << EAW) == EDEPTH)
         else $error("cc_engine: EDEPTH must be a power of two");
   end

   logic [EAW-1:0] edge_raddr;
   logic [VW-1:0]  edge_u, edge_v;
   logic [VW-1:0]  ctl_raddr, lbl_raddr, lbl_rdata;
   logic           lbl_we, lbl_init;
   logic [VW-1:0]  lbl_waddr, lbl_wdata;
   logic           edge_we;

   assign edge_we   = load_we && !busy;
   assign lbl_raddr = busy ? ctl_raddr : rd_addr;
   assign rd_label  = lbl_rdata;

   cc_edge_mem #(.VW(VW), .EDEPTH(EDEPTH)) u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (edge_we),
      .waddr (load_idx),
      .wu    (load_u),
      .wv    (load_v),
      .raddr (edge_raddr),
      .ru    (edge_u),
      .rv    (edge_v)
   );

   cc_label_mem #(.VW(VW)) u_labels (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lbl_we),
      .wr_init (lbl_init),
      .wr_addr (lbl_waddr),
      .wr_data (lbl_wdata),
      .rd_addr (lbl_raddr),
      .rd_data (lbl_rdata)
   );

   cc_ctrl #(.VW(VW), .EDEPTH(EDEPTH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cfg_nv     (cfg_nv),
      .cfg_ne     (cfg_ne),
      .edge_raddr (edge_raddr),
      .edge_u     (edge_u),
      .edge_v     (edge_v),
      .lbl_raddr  (ctl_raddr),
      .lbl_rdata  (lbl_rdata),
      .lbl_we     (lbl_we),
      .lbl_init   (lbl_init),
      .lbl_waddr  (lbl_waddr),
      .lbl_wdata  (lbl_wdata),
      .busy       (busy),
      .done       (done)
   );

   assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_start_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

   assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

endmodule

// File: tb/cc_engine_tb.sv
`timescale 1ns/1ps
module cc_engine_tb;

   localparam int VW     = 5;
   localparam int EDEPTH = 64;
   localparam int EAW    = 6;
   localparam int NMAX   = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           load_we = 1'b0;
   logic [EAW-1:0] load_idx = '0;
   logic [VW-1:0]  load_u = '0, load_v = '0;
   logic [VW:0]    cfg_nv = '0;
   logic [EAW:0]   cfg_ne = '0;
   logic           start = 1'b0;
   logic [VW-1:0]  rd_addr = '0;
   logic [VW-1:0]  rd_label;
   logic           busy, done;

   always #4 clk = ~clk;

   cc_engine #(.VW(VW), .EDEPTH(EDEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_idx(load_idx),
      .load_u(load_u), .load_v(load_v), .cfg_nv(cfg_nv), .cfg_ne(cfg_ne),
      .start(start), .rd_addr(rd_addr), .rd_label(rd_label),
      .busy(busy), .done(done)
   );

   int errors = 0;
   int checks = 0;
   int eu[EDEPTH];
   int ev[EDEPTH];
   int ne_cnt = 0;
   int exp_lab[NMAX];

   // scoreboard queues
   int    exp_q[$];
   string tag_q[$];
   int    addr_q[$];
   logic  rd_req = 1'b0;
   logic  rd_req_d = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // watchdog
   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   // monitor: pops one expected label per returned read
   always @(posedge clk) rd_req_d <= rd_req;
   always @(negedge clk) begin
      if (rd_req_d) begin
         int    e;
         string t;
         int    a;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = addr_q.pop_front();
         check(int'(rd_label) == e, $sformatf("%s vertex %0d", t, a), int'(rd_label), e);
      end
   end

   task automatic clear_graph();
      ne_cnt = 0;
   endtask

   task automatic add_edge(input int a, input int b);
      if (ne_cnt + 2 <= EDEPTH) begin
         eu[ne_cnt] = a; ev[ne_cnt] = b;
         eu[ne_cnt+1] = b; ev[ne_cnt+1] = a;
         ne_cnt += 2;
      end
   endtask

   task automatic load_graph();
      for (int k = 0; k < ne_cnt; k++) begin
         @(negedge clk);
         load_we = 1'b1; load_idx = EAW'(k);
         load_u = VW'(eu[k]); load_v = VW'(ev[k]);
      end
      @(negedge clk);
      load_we = 1'b0;
   endtask

   // reference: repeated min-relaxation over the edge list
   task automatic model(input int n);
      bit changed;
      for (int i = 0; i < NMAX; i++) exp_lab[i] = i;
      changed = 1'b1;
      while (changed) begin
         changed = 1'b0;
         for (int k = 0; k < ne_cnt; k++) begin
            int m;
            m = (exp_lab[eu[k]] < exp_lab[ev[k]]) ? exp_lab[eu[k]] : exp_lab[ev[k]];
            if (exp_lab[eu[k]] != m) begin exp_lab[eu[k]] = m; changed = 1'b1; end
            if (exp_lab[ev[k]] != m) begin exp_lab[ev[k]] = m; changed = 1'b1; end
         end
      end
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      check(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
   endtask

   task automatic run(input int n, input int ne);
      @(negedge clk);
      cfg_nv = (VW+1)'(n); cfg_ne = (EAW+1)'(ne); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R3 busy after start", int'(busy), 1);
      check(done == 1'b0, "R3 done cleared", int'(done), 0);
      wait_done();
   endtask

   task automatic read_all(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd_addr = VW'(i); rd_req = 1'b1;
         exp_q.push_back(exp_lab[i]);
         tag_q.push_back(tag);
         addr_q.push_back(i);
      end
      @(negedge clk);
      rd_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      check(done == 1'b0, "R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      check(done == 1'b0, "R1 done after reset", int'(done), 0);

      // fixed graph with a self loop: hooking (R5) and flattening (R6)
      clear_graph();
      add_edge(5, 3); add_edge(3, 7); add_edge(6, 1); add_edge(2, 2); add_edge(4, 0);
      load_graph();
      model(8);
      run(8, ne_cnt);
      read_all(8, "R5 R6 R8 R9 fixed");
      check(done == 1'b1, "R7 done holds while idle", int'(done), 1);

      // zero slots: identity labels (R4, R10)
      clear_graph();
      model(6);
      run(6, 0);
      read_all(6, "R4 R10 no edges");

      // long descending path: deep chains for flattening (R6)
      clear_graph();
      for (int i = 31; i > 0; i--) add_edge(i, i - 1);
      load_graph();
      model(32);
      run(32, ne_cnt);
      read_all(32, "R6 R8 path");

      // random graphs (R8)
      for (int g = 0; g < 8; g++) begin
         int n;
         int m;
         n = $urandom_range(32, 2);
         m = $urandom_range(32, 0);
         clear_graph();
         for (int k = 0; k < m; k++)
            add_edge($urandom_range(n - 1, 0), $urandom_range(n - 1, 0));
         load_graph();
         model(n);
         run(n, ne_cnt);
         read_all(n, $sformatf("R8 random%0d", g));
      end

      // write and second start during a run are ignored (R2, R11)
      clear_graph();
      add_edge(1, 2); add_edge(3, 4);
      load_graph();
      model(6);
      @(negedge clk);
      cfg_nv = 7'(6); cfg_ne = 7'(ne_cnt); start = 1'b1;
      @(negedge clk);
      start = 1'b1; cfg_nv = 7'(3); cfg_ne = 7'(2);
      load_we = 1'b1; load_idx = '0; load_u = 5'd0; load_v = 5'd5;
      @(negedge clk);
      start = 1'b0; load_we = 1'b0;
      check(busy == 1'b1, "R11 still busy", int'(busy), 1);
      wait_done();
      read_all(6, "R2 R11 busy inputs ignored");

      // rerun from the same store: slot 0 must be unchanged (R2)
      run(6, ne_cnt);
      read_all(6, "R2 store unchanged");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
      finish_run();
   end

endmodule